// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs an external 8-bit converter with a parallel output bus that converts on its own once it is told to start. A counter on the system clock produces an active-low start strobe. The strobe is one clock wide and repeats at a fixed, parameter-set interval. With the 50 MHz system clock and the default interval of 5 cycles, the start rate stays at or below 10 MHz, and each strobe lasts 20 ns.

The converter's active-low ready line is asynchronous to the system clock, so it passes through a synchronizer chain. The block reacts only to a high-to-low transition of the synchronized line, so one conversion yields exactly one capture however long ready stays low. The bus is sampled one cycle after the transition is seen, which gives the data time to settle. The byte is then presented on the sample output together with a single-cycle valid pulse.

The sample output is a valid-only stream and has no back-pressure. The consumer must take the byte in the cycle where valid is high. Between pulses, the sample register holds its last value.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is high, and in the cycle that follows a reset edge, conv_start_n is 1, sample_data is 0 and sample_valid is 0.
- R2: conv_start_n idles at 1. It goes to 0 for exactly one cycle in every START_PERIOD cycles (START_PERIOD >= 2; default 5).
- R3: The first low cycle of conv_start_n is the cycle after the first clock edge at which reset is low.
- R4: Take E as a clock edge at which rdy_n is sampled 0, where the previous sample (or the reset value) was 1. Then sample_valid is 1 in the cycle after edge E+SYNC_STAGES+1, which is E+3 by default.
- R5: The byte shown with a valid pulse is the value of adc_data sampled at the edge that raises sample_valid.
- R6: Holding rdy_n low for any length of time gives exactly one capture, and a rising rdy_n gives none.
- R7: sample_valid is never high for two cycles in a row, and sample_data changes only in cycles where sample_valid is 1.
- R8: A rdy_n low pulse that lasts a single clock cycle is still captured exactly once.
- R9: A reset that arrives after a falling rdy_n has been sampled, but before its capture, cancels that capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| rdy_n | input | 1 | Converter data-ready line, active low, asynchronous |
| adc_data | input | DATA_W | Converter parallel data bus |
| conv_start_n | output | 1 | Conversion start strobe, active low, one cycle wide |
| sample_data | output | DATA_W | Last captured byte |
| sample_valid | output | 1 | One-cycle pulse marking a new byte |

## Verification
The hardest cases to reach are a capture that is already in flight when reset arrives, and a ready pulse so short that it lives in only one synchronizer stage at a time. The stimulus covers both. It drops rdy_n for a single cycle several times in a row, and it lowers rdy_n for one sampled edge before raising reset. A behavioural model keeps a queue of pending capture times and uses it to predict every output on every cycle. It also predicts the strobe phase across reset, and long holds of ready low show that no second capture takes place.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // width of a counter able to hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/start_pulse_gen.sv
module start_pulse_gen #(
  parameter int PERIOD = 5
) (
  input  logic clk,
  input  logic rst,
  output logic strobe_n
);
  localparam int CW = adc_seq_pkg::cnt_width(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      strobe_n <= 1'b1;
    end else begin
      strobe_n <= (phase != '0);
      phase    <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  // checker: cycles spent high between two low cycles
  logic [CW:0] gap;
  logic        seen_low;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap      <= '0;
      seen_low <= 1'b0;
    end else if (!strobe_n) begin
      gap      <= '0;
      seen_low <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  a_r2_single_low: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> strobe_n);
  a_r2_period: assert property (@(posedge clk) disable iff (rst)
    (!strobe_n && seen_low) |-> (gap == (CW+1)'(PERIOD - 1)));
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> strobe_n);
endmodule

// File: rtl/ready_edge_detect.sv
module ready_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], rdy_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/sample_capture.sv
module sample_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall,
  input  logic [W-1:0] bus,
  output logic [W-1:0] data_q,
  output logic         valid_q
);
  logic arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm     <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      arm     <= fall;
      valid_q <= arm;
      if (arm) data_q <= bus;
    end
  end

  a_r7_one_cycle_valid: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(data_q));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int DATA_W       = 8,
  parameter int START_PERIOD = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              conv_start_n,
  output logic [DATA_W-1:0] sample_data,
  output logic              sample_valid
);
  logic rdy_fall;

  start_pulse_gen #(.PERIOD(START_PERIOD)) u_start (
    .clk(clk), .rst(rst), .strobe_n(conv_start_n)
  );

  ready_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .rdy_n(rdy_n), .fall(rdy_fall)
  );

  sample_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .fall(rdy_fall), .bus(adc_data),
    .data_q(sample_data), .valid_q(sample_valid)
  );

  // R4: a valid pulse follows a detected edge after the settle cycle
  a_r4_valid_from_edge: assert property (@(posedge clk) disable iff (rst)
    rdy_fall |=> ##1 sample_valid);
endmodule

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;
  localparam int CLK_P  = 20;
  localparam int PERIOD = 5;
  localparam int LAT    = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rdy_n = 1'b1;
  logic [7:0] adc_data = 8'h5A;
  logic       conv_start_n;
  logic [7:0] sample_data;
  logic       sample_valid;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;

  adc_conv_sequencer #(.DATA_W(8), .START_PERIOD(PERIOD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .rdy_n(rdy_n), .adc_data(adc_data),
    .conv_start_n(conv_start_n), .sample_data(sample_data),
    .sample_valid(sample_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pending capture times in a queue
  int   edge_n = 0;
  bit   last_smp = 1'b1;
  int   due[$];
  bit   started = 1'b0;
  bit   exp_start_n = 1'b1;
  bit   exp_valid = 1'b0;
  int   exp_data = 0;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      edge_n      = 0;
      last_smp    = 1'b1;
      due.delete();
      exp_start_n = 1'b1;
      exp_valid   = 1'b0;
      exp_data    = 0;
    end else begin
      edge_n++;
      exp_start_n = !(((edge_n - 1) % PERIOD) == 0);
      exp_valid   = 1'b0;
      if (due.size() > 0 && due[0] == edge_n) begin
        void'(due.pop_front());
        exp_valid = 1'b1;
        exp_data  = adc_data;
      end
      if (last_smp && !rdy_n) due.push_back(edge_n + LAT);
      last_smp = rdy_n;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(conv_start_n == exp_start_n, "R2 start strobe", conv_start_n, exp_start_n);
      check(sample_valid == exp_valid, "R4 valid timing", sample_valid, exp_valid);
      check(sample_data == exp_data[7:0], "R5 R7 sample data", sample_data, exp_data);
      if (sample_valid) vcount++;
    end
  end

  // bus pattern changes every cycle
  always @(negedge clk) adc_data <= adc_data * 8'd5 + 8'd3;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stim;
    int v0;
    cycles(3);
    // R1 reset state
    check(conv_start_n == 1'b1, "R1 start idle", conv_start_n, 1);
    check(sample_valid == 1'b0, "R1 valid clear", sample_valid, 0);
    check(sample_data == 8'd0, "R1 data clear", sample_data, 0);
    rst = 1'b0;
    cycles(1);
    // R3 first strobe right after reset release
    check(conv_start_n == 1'b0, "R3 first strobe", conv_start_n, 0);
    cycles(1);
    check(conv_start_n == 1'b1, "R3 strobe width", conv_start_n, 1);
    // normal conversions
    v0 = vcount;
    for (int i = 0; i < 6; i++) begin
      rdy_n = 1'b1; cycles(3);
      rdy_n = 1'b0; cycles(4);
    end
    rdy_n = 1'b1; cycles(6);
    check(vcount - v0 == 6, "R4 one capture per conversion", vcount - v0, 6);
    // long low hold
    v0 = vcount;
    rdy_n = 1'b0; cycles(40);
    check(vcount - v0 == 1, "R6 long low single capture", vcount - v0, 1);
    v0 = vcount;
    rdy_n = 1'b1; cycles(10);
    check(vcount - v0 == 0, "R6 rising gives none", vcount - v0, 0);
    // one-cycle low pulses
    v0 = vcount;
    for (int i = 0; i < 5; i++) begin
      rdy_n = 1'b0; cycles(1);
      rdy_n = 1'b1; cycles(3);
    end
    cycles(4);
    check(vcount - v0 == 5, "R8 short pulses captured", vcount - v0, 5);
    // reset while a capture is pending
    v0 = vcount;
    rdy_n = 1'b0; cycles(1);
    rst = 1'b1; rdy_n = 1'b1; cycles(2);
    check(sample_data == 8'd0, "R1 data after reset", sample_data, 0);
    rst = 1'b0; cycles(8);
    check(vcount - v0 == 0, "R9 pending capture cancelled", vcount - v0, 0);
    // resume after reset
    v0 = vcount;
    rdy_n = 1'b0; cycles(6);
    rdy_n = 1'b1; cycles(4);
    check(vcount - v0 == 1, "R4 capture after reset", vcount - v0, 1);
  endtask

  initial begin
    fork
      stim();
      begin
        cycles(100000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule